// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter. It drives a trial code into an external DAC and reads back one comparator bit, which is high when the analog input is at or above the trial level. It searches from the most significant bit down over 8 or 10 bits. It picks one of four analog channels and enables the reference ladder only while a conversion is running. When a conversion ends it writes the code to a result register and raises a one-cycle done pulse.

A conversion begins with a sampling period. The trial decisions follow, one per cycle, and idle cycles then pad the conversion to a fixed length. That length depends on the resolution and on whether the sample-and-hold path is used. Software arms the block with a start bit. In software-trigger mode the start bit alone launches a conversion. In timer-trigger mode, a timer pulse launches a conversion only while the start bit is already set. In one-shot mode the start bit clears itself when the conversion ends. In repeat mode, which always runs at 8 bits, conversions follow each other until software clears the start bit.

Top module: `sar_seq_top`

## Requirements
- R1: With `trig_sel`=0, a one-cycle `start_set` pulse sets the start bit at the next edge and launches a conversion at the edge after that. `busy` and `ref_en` are high from the launch edge on.
- R2: `done` goes high exactly T clock edges after the launch edge. T is 49 (8-bit, direct), 59 (10-bit, direct), 28 (8-bit, sample-and-hold) or 33 (10-bit, sample-and-hold).
- R3: The search runs MSB first. The first trial code on `dac_code` is 0x80 at 8 bits and 0x200 at 10 bits. For an input below full scale, the result equals the input code. At 8 bits, `dac_code[9:8]` stays 0.
- R4: When every comparator decision is high (input at or above the reference), the result is 0x3FF at 10 bits and 0xFF at 8 bits.
- R5: With `cfg_repeat`=1, conversions run at 8 bits even if `cfg_res10`=1. They follow each other with one `done` every 8-bit T cycles, and the start bit stays set.
- R6: Pulsing `start_clr` during a repeat sequence clears the start bit. The current conversion still completes and delivers its result. `busy` then falls with that `done`, and no further conversion starts.
- R7: In one-shot mode the start bit reads 0 once `done` is high.
- R8: With `trig_sel`=1, a conversion starts only on a `timer_pulse` while the start bit is 1. A timer pulse while the start bit is 0 has no effect, and the start bit alone does not launch a conversion. After the launching pulse, `done` rises T edges later.
- R9: During a conversion, `chan_sel` shows the channel that `cfg_chan` held at launch, and it stays stable for the whole conversion.
- R10: `ref_en` is high while a conversion is active and low when idle. `dac_code` is 0 whenever `ref_en` is low.
- R11: `done` is high for exactly one cycle. `result` updates only at the edge that raises `done` and holds its value otherwise.
- R12: After synchronous reset, `busy`, `ref_en`, `done`, `start_bit`, `result` and `dac_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_set | input | 1 | Software write of 1 to the start bit |
| start_clr | input | 1 | Software write of 0 to the start bit (wins over start_set) |
| trig_sel | input | 1 | 0: software trigger, 1: timer-gated trigger |
| cfg_repeat | input | 1 | 1: repeat mode, 0: one-shot |
| cfg_res10 | input | 1 | 1: 10-bit resolution, 0: 8-bit |
| cfg_sh | input | 1 | 1: use sample-and-hold timing |
| cfg_chan | input | 2 | Analog channel to convert |
| timer_pulse | input | 1 | Timer interrupt pulse |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| dac_code | output | 10 | Trial code for the DAC |
| chan_sel | output | 2 | Channel multiplexer select |
| ref_en | output | 1 | Reference ladder connect |
| busy | output | 1 | Conversion in progress |
| start_bit | output | 1 | Current value of the start bit |
| result | output | 10 | Last conversion result, zero-extended at 8 bits |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check that `done` lasts one cycle, that `result` holds between completions, and that `done` is always preceded by an active reference. They also check that the upper DAC bits stay clear at 8 bits, that a repeat conversion never runs at 10 bits, and that the channel stays stable within a conversion. Finally, they check that a timer-mode launch was caused by a pulse while the start bit was set. Only the bench scenarios can show the exact cycle budget for each mode, the numerical result of the search against a modelled input, the full-scale clamp, and how repeat mode ends after the start bit is cleared.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int CH_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_TRIAL,
        PH_PAD
    } phase_e;

    typedef struct packed {
        logic            res10;
        logic            sh;
        logic            rpt;
        logic [CH_W-1:0] chan;
    } conv_cfg_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sar_start_ctl.sv
module sar_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic start_set,
    input  logic start_clr,
    input  logic trig_sel,
    input  logic timer_pulse,
    input  logic busy,
    input  logic finish,
    input  logic cur_rpt,
    output logic go,
    output logic launch
);
    logic go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q <= 1'b0;
        end else if (start_clr) begin
            go_q <= 1'b0;
        end else if (start_set) begin
            go_q <= 1'b1;
        end else if (finish && !cur_rpt) begin
            go_q <= 1'b0;
        end
    end

    assign go     = go_q;
    assign launch = !busy && go_q && (trig_sel ? timer_pulse : 1'b1);

endmodule

// File: rtl/sar_seq_timing.sv
module sar_seq_timing
    import sar_seq_pkg::*;
#(
    parameter int CYC_8_DIR  = 49,
    parameter int CYC_10_DIR = 59,
    parameter int CYC_8_SH   = 28,
    parameter int CYC_10_SH  = 33,
    parameter int SMP_DIR    = 8,
    parameter int SMP_SH     = 4,
    parameter int RES_LO     = 8,
    parameter int RES_HI     = 10,
    parameter int IDX_W      = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  conv_cfg_t       cfg_in,
    input  logic            go,
    input  logic            start_clr,
    output logic            busy,
    output phase_e          phase,
    output logic [IDX_W-1:0] trial_idx,
    output logic            finish,
    output logic            cur_res10,
    output logic            cur_rpt,
    output logic [CH_W-1:0] cur_chan
);
    localparam int CYC_MAX = max_of4(CYC_8_DIR, CYC_10_DIR, CYC_8_SH, CYC_10_SH);
    localparam int CNT_W   = $clog2(CYC_MAX + 1);

    localparam logic [CNT_W-1:0] B8D  = CNT_W'(CYC_8_DIR);
    localparam logic [CNT_W-1:0] B10D = CNT_W'(CYC_10_DIR);
    localparam logic [CNT_W-1:0] B8S  = CNT_W'(CYC_8_SH);
    localparam logic [CNT_W-1:0] B10S = CNT_W'(CYC_10_SH);
    localparam logic [CNT_W-1:0] SD   = CNT_W'(SMP_DIR);
    localparam logic [CNT_W-1:0] SS   = CNT_W'(SMP_SH);
    localparam logic [CNT_W-1:0] NLO  = CNT_W'(RES_LO);
    localparam logic [CNT_W-1:0] NHI  = CNT_W'(RES_HI);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    conv_cfg_t        cur_q;
    logic [CNT_W-1:0] budget;
    logic [CNT_W-1:0] smp_len;
    logic [CNT_W-1:0] nbits;
    logic             keep_going;

    always_comb begin
        case ({cur_q.res10, cur_q.sh})
            2'b00:   budget = B8D;
            2'b10:   budget = B10D;
            2'b01:   budget = B8S;
            default: budget = B10S;
        endcase
        smp_len = cur_q.sh    ? SS  : SD;
        nbits   = cur_q.res10 ? NHI : NLO;
    end

    assign finish     = busy_q && (cnt_q == budget - 1'b1);
    assign keep_going = cur_q.rpt && go && !start_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cur_q  <= '0;
        end else if (!busy_q) begin
            if (launch) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                cur_q  <= cfg_in;
            end
        end else if (finish) begin
            cnt_q  <= '0;
            busy_q <= keep_going;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (!busy_q)                   phase = PH_IDLE;
        else if (cnt_q < smp_len)      phase = PH_SAMPLE;
        else if (cnt_q < smp_len + nbits) phase = PH_TRIAL;
        else                           phase = PH_PAD;
    end

    assign trial_idx = IDX_W'(cnt_q - smp_len);
    assign busy      = busy_q;
    assign cur_res10 = cur_q.res10;
    assign cur_rpt   = cur_q.rpt;
    assign cur_chan  = cur_q.chan;

    // R5: a repeat conversion never runs at the high resolution
    p_repeat_low_res_r5: assert property (@(posedge clk) disable iff (rst)
        busy_q && cur_q.rpt |-> !cur_q.res10);

    // R9: channel held for the whole conversion
    p_chan_stable_r9: assert property (@(posedge clk) disable iff (rst)
        busy_q && $past(busy_q) |-> $stable(cur_q.chan));

endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg
    import sar_seq_pkg::*;
#(
    parameter int RES_LO = 8,
    parameter int RES_HI = 10,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              res10,
    input  logic [IDX_W-1:0]  trial_idx,
    input  logic              cmp_in,
    output logic [RES_HI-1:0] dac_code,
    output logic [RES_HI-1:0] acc
);
    localparam logic [IDX_W-1:0] TOP_LO = IDX_W'(RES_LO - 1);
    localparam logic [IDX_W-1:0] TOP_HI = IDX_W'(RES_HI - 1);

    logic [RES_HI-1:0] acc_q;
    logic [IDX_W-1:0]  pos;
    logic [RES_HI-1:0] probe;

    always_comb begin
        pos   = (res10 ? TOP_HI : TOP_LO) - trial_idx;
        probe = RES_HI'(1) << pos;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (phase == PH_SAMPLE) begin
            acc_q <= '0;
        end else if (phase == PH_TRIAL && cmp_in) begin
            acc_q <= acc_q | probe;
        end
    end

    assign dac_code = (phase == PH_TRIAL) ? (acc_q | probe) : '0;
    assign acc      = acc_q;

    // R3: bits above the low resolution stay clear at 8 bits
    p_dac_low_width_r3: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) && !res10 |-> dac_code[RES_HI-1:RES_LO] == '0);

    // R10: no DAC drive while idle
    p_dac_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        phase == PH_IDLE |-> dac_code == '0);

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int CYC_8_DIR  = 49,
    parameter int CYC_10_DIR = 59,
    parameter int CYC_8_SH   = 28,
    parameter int CYC_10_SH  = 33,
    parameter int SMP_DIR    = 8,
    parameter int SMP_SH     = 4,
    parameter int RES_LO     = 8,
    parameter int RES_HI     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_set,
    input  logic              start_clr,
    input  logic              trig_sel,
    input  logic              cfg_repeat,
    input  logic              cfg_res10,
    input  logic              cfg_sh,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              timer_pulse,
    input  logic              cmp_in,
    output logic [RES_HI-1:0] dac_code,
    output logic [CH_W-1:0]   chan_sel,
    output logic              ref_en,
    output logic              busy,
    output logic              start_bit,
    output logic [RES_HI-1:0] result,
    output logic              done
);
    localparam int IDX_W = $clog2(RES_HI);

    logic              go;
    logic              launch;
    logic              busy_w;
    logic              finish;
    logic              cur_res10;
    logic              cur_rpt;
    logic [CH_W-1:0]   cur_chan;
    phase_e            phase;
    logic [IDX_W-1:0]  trial_idx;
    logic [RES_HI-1:0] acc;
    conv_cfg_t         cfg_in;
    logic [RES_HI-1:0] result_q;
    logic              done_q;

    always_comb begin
        cfg_in.res10 = cfg_res10 && !cfg_repeat;
        cfg_in.sh    = cfg_sh;
        cfg_in.rpt   = cfg_repeat;
        cfg_in.chan  = cfg_chan;
    end

    sar_start_ctl u_start (
        .clk         (clk),
        .rst         (rst),
        .start_set   (start_set),
        .start_clr   (start_clr),
        .trig_sel    (trig_sel),
        .timer_pulse (timer_pulse),
        .busy        (busy_w),
        .finish      (finish),
        .cur_rpt     (cur_rpt),
        .go          (go),
        .launch      (launch)
    );

    sar_seq_timing #(
        .CYC_8_DIR  (CYC_8_DIR),
        .CYC_10_DIR (CYC_10_DIR),
        .CYC_8_SH   (CYC_8_SH),
        .CYC_10_SH  (CYC_10_SH),
        .SMP_DIR    (SMP_DIR),
        .SMP_SH     (SMP_SH),
        .RES_LO     (RES_LO),
        .RES_HI     (RES_HI),
        .IDX_W      (IDX_W)
    ) u_timing (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .cfg_in    (cfg_in),
        .go        (go),
        .start_clr (start_clr),
        .busy      (busy_w),
        .phase     (phase),
        .trial_idx (trial_idx),
        .finish    (finish),
        .cur_res10 (cur_res10),
        .cur_rpt   (cur_rpt),
        .cur_chan  (cur_chan)
    );

    sar_search_reg #(
        .RES_LO (RES_LO),
        .RES_HI (RES_HI),
        .IDX_W  (IDX_W)
    ) u_search (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .res10     (cur_res10),
        .trial_idx (trial_idx),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .acc       (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                result_q <= acc;
            end
        end
    end

    assign chan_sel  = cur_chan;
    assign ref_en    = busy_w;
    assign busy      = busy_w;
    assign start_bit = go;
    assign result    = result_q;
    assign done      = done_q;

    // R11: completion flag lasts one cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R11: result only moves together with done
    p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(result_q));

    // R10: every completion follows an active reference period
    p_ref_before_done_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(ref_en));

    // R8: a timer-mode launch needs the pulse and the armed start bit
    p_timer_gate_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_w) && $past(trig_sel) |-> $past(timer_pulse) && $past(go));

    // R7: one-shot completion disarms the start bit
    p_oneshot_disarm_r7: assert property (@(posedge clk) disable iff (rst)
        finish && !cur_rpt && !start_set |=> !go);

endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_set = 1'b0;
    logic       start_clr = 1'b0;
    logic       trig_sel = 1'b0;
    logic       cfg_repeat = 1'b0;
    logic       cfg_res10 = 1'b0;
    logic       cfg_sh = 1'b0;
    logic [1:0] cfg_chan = 2'd0;
    logic       timer_pulse = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [1:0] chan_sel;
    logic       ref_en;
    logic       busy;
    logic       start_bit;
    logic [9:0] result;
    logic       done;
    logic [9:0] vin = 10'd0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    // comparator model: high when the input is at or above the trial level
    assign cmp_in = (vin >= dac_code);

    sar_seq_top dut (
        .clk         (clk),
        .rst         (rst),
        .start_set   (start_set),
        .start_clr   (start_clr),
        .trig_sel    (trig_sel),
        .cfg_repeat  (cfg_repeat),
        .cfg_res10   (cfg_res10),
        .cfg_sh      (cfg_sh),
        .cfg_chan    (cfg_chan),
        .timer_pulse (timer_pulse),
        .cmp_in      (cmp_in),
        .dac_code    (dac_code),
        .chan_sel    (chan_sel),
        .ref_en      (ref_en),
        .busy        (busy),
        .start_bit   (start_bit),
        .result      (result),
        .done        (done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // {res10, sh, chan[1:0], vin[9:0], expected result[9:0], cycle budget[6:0]}
    localparam int NV = 8;
    localparam logic [30:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 2'd0, 10'd0,    10'd0,    7'd49},
        {1'b0, 1'b0, 2'd1, 10'd173,  10'd173,  7'd49},
        {1'b1, 1'b0, 2'd2, 10'd700,  10'd700,  7'd59},
        {1'b1, 1'b1, 2'd3, 10'd1023, 10'd1023, 7'd33},
        {1'b0, 1'b1, 2'd0, 10'd255,  10'd255,  7'd28},
        {1'b0, 1'b1, 2'd2, 10'd600,  10'd255,  7'd28},
        {1'b1, 1'b1, 2'd1, 10'd512,  10'd512,  7'd33},
        {1'b1, 1'b0, 2'd3, 10'd1,    10'd1,    7'd59}
    };

    initial begin
        int k;
        int first_dac;
        int chan_ok;
        int ref_ok;
        int dones;
        logic [9:0] held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk("R12 busy", busy, 0);
        chk("R12 ref_en", ref_en, 0);
        chk("R12 done", done, 0);
        chk("R12 start_bit", start_bit, 0);
        chk("R12 result", result, 0);
        chk("R12 dac_code", dac_code, 0);

        // table walk: software-trigger one-shot conversions
        for (int i = 0; i < NV; i++) begin
            cfg_res10 = VEC[i][30];
            cfg_sh    = VEC[i][29];
            cfg_chan  = VEC[i][28:27];
            vin       = VEC[i][26:17];
            trig_sel  = 1'b0;
            cfg_repeat = 1'b0;
            start_set = 1'b1;
            k = 0;
            first_dac = -1;
            chan_ok = 1;
            ref_ok = 1;
            while (k < 300) begin
                @(negedge clk);
                start_set = 1'b0;
                k = k + 1;
                if (done) break;
                if (busy && chan_sel != VEC[i][28:27]) chan_ok = 0;
                if (busy && !ref_en) ref_ok = 0;
                if (first_dac < 0 && dac_code != 10'd0) first_dac = int'(dac_code);
                // cycle k==2 is the first cycle after the launch edge
                if (k == 2) chk("R1 busy after launch", busy, 1);
            end
            chk("R2 launch-to-done cycles", k, int'(VEC[i][6:0]) + 2);
            chk("R3 R4 result", result, int'(VEC[i][16:7]));
            chk("R3 first trial code", first_dac, VEC[i][30] ? 512 : 128);
            chk("R7 start bit cleared", start_bit, 0);
            chk("R9 channel during conversion", chan_ok, 1);
            chk("R10 ref during conversion", ref_ok, 1);
            held = result;
            @(negedge clk);
            chk("R11 done single cycle", done, 0);
            chk("R10 ref idle", ref_en, 0);
            repeat (3) @(negedge clk);
            chk("R11 result held", result, int'(held));
        end

        // R8: timer-gated start
        trig_sel  = 1'b1;
        cfg_res10 = 1'b0;
        cfg_sh    = 1'b1;
        cfg_chan  = 2'd2;
        vin       = 10'd90;
        timer_pulse = 1'b1;
        @(negedge clk);
        timer_pulse = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 pulse ignored while unarmed", busy, 0);
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 armed but no pulse", busy, 0);
        chk("R8 start bit armed", start_bit, 1);
        timer_pulse = 1'b1;
        k = 0;
        while (k < 300) begin
            @(negedge clk);
            timer_pulse = 1'b0;
            k = k + 1;
            if (done) break;
        end
        chk("R8 pulse-to-done cycles", k, 29);
        chk("R8 result", result, 90);
        chk("R7 timer one-shot disarm", start_bit, 0);
        repeat (2) @(negedge clk);

        // R5/R6: repeat mode forced to 8 bits
        trig_sel   = 1'b0;
        cfg_repeat = 1'b1;
        cfg_res10  = 1'b1;
        cfg_sh     = 1'b0;
        cfg_chan   = 2'd1;
        vin        = 10'd1023;
        start_set  = 1'b1;
        k = 0;
        while (k < 300) begin
            @(negedge clk);
            start_set = 1'b0;
            k = k + 1;
            if (done) break;
        end
        chk("R5 first repeat latency (8-bit)", k, 51);
        chk("R4 R5 full scale at 8 bits", result, 255);
        vin = 10'd40;
        k = 0;
        while (k < 300) begin
            @(negedge clk);
            k = k + 1;
            if (done) break;
        end
        chk("R5 back-to-back interval", k, 49);
        chk("R5 second result", result, 40);
        chk("R5 start bit kept", start_bit, 1);
        chk("R5 still busy", busy, 1);
        start_clr = 1'b1;
        @(negedge clk);
        start_clr = 1'b0;
        chk("R6 start bit cleared", start_bit, 0);
        chk("R6 current conversion continues", busy, 1);
        k = 1;
        while (k < 300) begin
            @(negedge clk);
            k = k + 1;
            if (done) break;
        end
        chk("R6 final conversion completes", k, 49);
        chk("R6 final result", result, 40);
        chk("R6 busy falls", busy, 0);
        dones = 0;
        for (int j = 0; j < 80; j++) begin
            @(negedge clk);
            if (done || busy) dones = dones + 1;
        end
        chk("R6 no further conversion", dones, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule